// File: doc/BRIEF.md
# Hybrid Coarse/Fine Digital Pulse-Width Modulator

This block turns an n-bit duty command into a pulse-width modulated signal for a switching power stage. The command is split in two. Its upper bits are matched against a coarse counter that runs across the switching period. Its lower bits choose, through a 2^m-to-1 selector, one tap of a short chain of fine cells. Each fine cell covers an equal fraction of a coarse step. The output flop is set at the start of every period. It is cleared when the coarse count equals the upper bits and the chosen fine tap is active. The time base therefore needs only 2^m fine steps per coarse step, not a clock of Fsw·2^n for a single long counter.

The fine chain is a ring of registered cells that carries a single token. It moves one cell each time the fine-step enable is high. A chip would drive that enable from a faster phase source. In this model it is an input, so every step of the period is under the caller's control. A period is 2^n fine steps long. The duty command is taken at each period boundary. A one-cycle flag marks each boundary.

Top module: `hybrid_dpwm`

## Requirements
- R1: While reset is asserted, `pwm_o` and `period_start_o` are both 0.
- R2: One switching period spans exactly 2^DUTY_W fine steps, where a fine step is a clock edge with `fine_step_en` high. `period_start_o` is high for exactly one clock per period. That clock is the one after the fine step that wraps the time base.
- R3: For a code d with 0 < d < 2^DUTY_W-1, `pwm_o` stays high for exactly d fine steps after the period start. This is (d >> FINE_W) coarse steps of 2^FINE_W fine steps, plus (d mod 2^FINE_W) fine taps.
- R4: A duty code of 0 keeps `pwm_o` low for the whole period.
- R5: The all-ones duty code keeps `pwm_o` high for the whole period, across the period boundary as well.
- R6: `duty_i` is sampled only on the fine step that starts a period. A change in the middle of a period affects only the next period.
- R7: When `fine_step_en` is low, the time base does not advance: `pwm_o` holds its value and no `period_start_o` is produced.
- R8: `pwm_o` rises only in the clock in which `period_start_o` is high.
- R9: The pulse width is monotonic in the duty code. This includes the step from the last fine tap of one coarse count to tap 0 of the next coarse count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fine_step_en | input | 1 | Advances the fine chain by one cell when high |
| duty_i | input | DUTY_W | Duty command in fine steps; upper bits are coarse, lower FINE_W bits select the fine tap |
| pwm_o | output | 1 | Modulated output from the set/reset flop |
| period_start_o | output | 1 | One-clock flag at each period boundary |

## Verification
The modulator is driven with duty codes that use only the coarse bits (4), only the fine bits (1, 3), and both (5, 37, 62). This separates an error in the coarse compare from an error in the fine-tap selector or its order. Codes 3, 4 and 5 cross a coarse boundary, so a selector that skips taps or sends the token the wrong way shows up as a non-monotonic width. The fine-step enable is pulsed every clock, every second clock and every third clock. This separates widths counted in fine steps from widths counted in clocks. Codes 0 and all-ones, a change of duty in the middle of a period, and a stall of the enable check the boundary, latching and hold behaviour.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
   // How the fine-tap selector is built
   typedef enum logic {
      TAP_SEL_INDEX = 1'b0,  // plain indexed part-select
      TAP_SEL_ANDOR = 1'b1   // decoded AND-OR tree
   } tap_sel_e;

   localparam int unsigned DUTY_W_MAX = 16;
endpackage

// File: rtl/dpwm_tap_chain.sv
module dpwm_tap_chain
   import dpwm_pkg::*;
#(
   parameter int unsigned FINE_W    = 2,
   parameter tap_sel_e    SEL_STYLE = TAP_SEL_ANDOR
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_i,
   input  logic [FINE_W-1:0] tap_sel_i,
   output logic              at_last_o,
   output logic              tap_hit_nx_o
);
   localparam int unsigned CELLS = 1 << FINE_W;
   localparam logic [CELLS-1:0] TOKEN_RST = {1'b1, {(CELLS-1){1'b0}}};

   logic [CELLS-1:0] cell_q;
   logic [CELLS-1:0] cell_nx;

   // ring of equal cells: each takes the token from its predecessor
   for (genvar c = 0; c < CELLS; c++) begin : g_cell
      localparam int unsigned PREV = (c == 0) ? CELLS - 1 : c - 1;
      assign cell_nx[c] = cell_q[PREV];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cell_q <= TOKEN_RST;
      else if (step_i) cell_q <= cell_nx;
   end

   assign at_last_o = cell_q[CELLS-1];

   // selector looks at the cell the token enters on this step
   if (SEL_STYLE == TAP_SEL_ANDOR) begin : g_andor
      logic [CELLS-1:0] term;
      for (genvar c = 0; c < CELLS; c++) begin : g_term
         assign term[c] = cell_nx[c] & (tap_sel_i == FINE_W'(c));
      end
      assign tap_hit_nx_o = |term;
   end else begin : g_index
      assign tap_hit_nx_o = cell_nx[tap_sel_i];
   end
endmodule

// File: rtl/dpwm_coarse_ctr.sv
module dpwm_coarse_ctr #(
   parameter int unsigned COARSE_W = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                step_i,
   input  logic                fine_carry_i,
   output logic [COARSE_W-1:0] count_nx_o,
   output logic                wrap_o
);
   logic [COARSE_W-1:0] count_q;
   logic                advance;

   assign advance    = step_i & fine_carry_i;
   assign count_nx_o = fine_carry_i ? count_q + 1'b1 : count_q;
   assign wrap_o     = advance & (&count_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       count_q <= '1;
      else if (advance) count_q <= count_q + 1'b1;
   end
endmodule

// File: rtl/dpwm_sr_out.sv
module dpwm_sr_out #(
   parameter int unsigned DUTY_W = 6,
   parameter int unsigned FINE_W = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     step_i,
   input  logic                     wrap_i,
   input  logic [DUTY_W-1:0]        duty_i,
   input  logic [DUTY_W-FINE_W-1:0] coarse_nx_i,
   input  logic                     tap_hit_nx_i,
   output logic [DUTY_W-1:0]        duty_q_o,
   output logic                     pwm_o,
   output logic                     start_o
);
   localparam int unsigned COARSE_W = DUTY_W - FINE_W;

   logic [DUTY_W-1:0] duty_q;
   logic              full_scale;
   logic              coarse_eq;
   logic              clear_now;

   assign full_scale = &duty_q;
   assign coarse_eq  = (coarse_nx_i == duty_q[DUTY_W-1:FINE_W]);
   assign clear_now  = step_i & coarse_eq & tap_hit_nx_i & ~full_scale;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         duty_q  <= '0;
         pwm_o   <= 1'b0;
         start_o <= 1'b0;
      end else begin
         start_o <= wrap_i;
         if (wrap_i) begin
            duty_q <= duty_i;
            pwm_o  <= |duty_i;
         end else if (clear_now) begin
            pwm_o  <= 1'b0;
         end
      end
   end

   assign duty_q_o = duty_q;

   if (COARSE_W < 1) begin : g_bad_split
      $error("dpwm_sr_out: coarse part must be at least one bit");
   end
endmodule

// File: rtl/hybrid_dpwm.sv
module hybrid_dpwm
   import dpwm_pkg::*;
#(
   parameter int unsigned DUTY_W    = 6,
   parameter int unsigned FINE_W    = 2,
   parameter tap_sel_e    SEL_STYLE = TAP_SEL_ANDOR
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fine_step_en,
   input  logic [DUTY_W-1:0] duty_i,
   output logic              pwm_o,
   output logic              period_start_o
);
   localparam int unsigned COARSE_W = DUTY_W - FINE_W;

   if (FINE_W < 1) begin : g_chk_fine
      $error("hybrid_dpwm: FINE_W must be at least 1");
   end
   if (DUTY_W <= FINE_W) begin : g_chk_split
      $error("hybrid_dpwm: DUTY_W must exceed FINE_W");
   end
   if (DUTY_W > DUTY_W_MAX) begin : g_chk_width
      $error("hybrid_dpwm: DUTY_W above supported maximum");
   end

   logic                fine_last;
   logic                tap_hit_nx;
   logic [COARSE_W-1:0] coarse_nx;
   logic                wrap;
   logic [DUTY_W-1:0]   duty_q;

   dpwm_tap_chain #(
      .FINE_W   (FINE_W),
      .SEL_STYLE(SEL_STYLE)
   ) u_fine (
      .clk         (clk),
      .rst_n       (rst_n),
      .step_i      (fine_step_en),
      .tap_sel_i   (duty_q[FINE_W-1:0]),
      .at_last_o   (fine_last),
      .tap_hit_nx_o(tap_hit_nx)
   );

   dpwm_coarse_ctr #(
      .COARSE_W(COARSE_W)
   ) u_coarse (
      .clk         (clk),
      .rst_n       (rst_n),
      .step_i      (fine_step_en),
      .fine_carry_i(fine_last),
      .count_nx_o  (coarse_nx),
      .wrap_o      (wrap)
   );

   dpwm_sr_out #(
      .DUTY_W(DUTY_W),
      .FINE_W(FINE_W)
   ) u_out (
      .clk         (clk),
      .rst_n       (rst_n),
      .step_i      (fine_step_en),
      .wrap_i      (wrap),
      .duty_i      (duty_i),
      .coarse_nx_i (coarse_nx),
      .tap_hit_nx_i(tap_hit_nx),
      .duty_q_o    (duty_q),
      .pwm_o       (pwm_o),
      .start_o     (period_start_o)
   );
endmodule

// File: rtl/hybrid_dpwm_chk.sv
module hybrid_dpwm_chk #(
   parameter int unsigned DUTY_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fine_step_en,
   input logic              pwm_o,
   input logic              period_start_o,
   input logic [DUTY_W-1:0] duty_q
);
   // R2
   start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      period_start_o |=> !period_start_o);

   // R7
   hold_pwm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fine_step_en |=> $stable(pwm_o));

   // R7
   hold_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fine_step_en |=> !period_start_o);

   // R8
   rise_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwm_o) |-> period_start_o);

   // R4
   zero_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (period_start_o && duty_q == '0) |-> !pwm_o);

   // R5
   full_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (period_start_o && (&duty_q)) |-> pwm_o);

   // R6
   duty_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !period_start_o |-> $stable(duty_q));
endmodule

bind hybrid_dpwm hybrid_dpwm_chk #(.DUTY_W(DUTY_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .fine_step_en  (fine_step_en),
   .pwm_o         (pwm_o),
   .period_start_o(period_start_o),
   .duty_q        (duty_q)
);

// File: tb/tb_hybrid_dpwm.sv
module tb_hybrid_dpwm;
   localparam int DW   = 6;
   localparam int FW   = 2;
   localparam int STEPS = 1 << DW;
   localparam int FULL = STEPS - 1;
   localparam int NV   = 10;
   // stimulus table: duty code and fine-step spacing in clocks
   localparam int VEC_DUTY [NV] = '{1, 3, 4, 5, 32, 62, 63, 0, 37, 10};
   localparam int VEC_SP   [NV] = '{1, 1, 1, 1,  1,  1,  1, 1,  2,  3};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          fine_step_en = 1'b0;
   logic [DW-1:0] duty_i = '0;
   logic          pwm_o;
   logic          period_start_o;

   int checks = 0;
   int fails  = 0;
   int sp = 1;
   int gcnt = 0;
   logic gen_on = 1'b0;
   int rise_bad = 0;
   int widths [NV];

   always #4 clk = ~clk;

   hybrid_dpwm #(.DUTY_W(DW), .FINE_W(FW)) dut (
      .clk(clk), .rst_n(rst_n), .fine_step_en(fine_step_en),
      .duty_i(duty_i), .pwm_o(pwm_o), .period_start_o(period_start_o)
   );

   always @(negedge clk) begin
      if (!gen_on) begin
         fine_step_en <= 1'b0;
         gcnt <= 0;
      end else begin
         fine_step_en <= (gcnt == 0);
         gcnt <= (gcnt >= sp - 1) ? 0 : gcnt + 1;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic sync_start();
      @(negedge clk);
      while (!period_start_o) @(negedge clk);
   endtask

   // starts on a sample with period_start_o high, ends on the next one
   task automatic measure(input int chg_at, input int nd, output int hi, output int len);
      logic prev;
      hi = 0; len = 0; prev = pwm_o;
      do begin
         if (pwm_o) hi++;
         if (pwm_o && !prev && !period_start_o) rise_bad++;
         prev = pwm_o;
         if (len == chg_at) duty_i = DW'(nd);
         len++;
         @(negedge clk);
      end while (!period_start_o);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      int hi, len;
      repeat (3) @(negedge clk);
      check("R1 pwm in reset", int'(pwm_o), 0);
      check("R1 start in reset", int'(period_start_o), 0);
      rst_n = 1'b1;

      // R7: no enable, no progress
      begin
         int starts = 0;
         for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            if (period_start_o) starts++;
         end
         check("R7 no start without enable", starts, 0);
         check("R7 pwm idle without enable", int'(pwm_o), 0);
      end

      // table walk: R2 R3 R4 R5
      for (int v = 0; v < NV; v++) begin
         int exp_hi;
         sp = VEC_SP[v];
         duty_i = DW'(VEC_DUTY[v]);
         gen_on = 1'b1;
         sync_start();
         measure(-1, 0, hi, len);
         widths[v] = hi;
         exp_hi = (VEC_DUTY[v] == FULL) ? STEPS * sp : VEC_DUTY[v] * sp;
         if (VEC_DUTY[v] == 0)         check("R4 zero duty width", hi, exp_hi);
         else if (VEC_DUTY[v] == FULL) check("R5 full duty width", hi, exp_hi);
         else                          check("R3 duty width", hi, exp_hi);
         check("R2 period length", len, STEPS * sp);
      end

      // R9: widths grow across the coarse boundary (codes 3, 4, 5)
      check("R9 width 3<4", int'(widths[1] < widths[2]), 1);
      check("R9 width 4<5", int'(widths[2] < widths[3]), 1);

      // R6: change in mid-period only takes effect next period
      sp = 1;
      duty_i = DW'(20);
      sync_start();
      measure(-1, 0, hi, len);
      measure(5, 50, hi, len);
      check("R6 old duty kept in period", hi, 20);
      measure(-1, 0, hi, len);
      check("R6 new duty next period", hi, 50);

      // R7: stall in mid-period holds the output
      duty_i = DW'(30);
      sync_start();
      measure(-1, 0, hi, len);
      repeat (10) @(negedge clk);
      gen_on = 1'b0;
      repeat (2) @(negedge clk);
      begin
         int starts = 0, lows = 0;
         for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (period_start_o) starts++;
            if (!pwm_o) lows++;
         end
         check("R7 stalled start count", starts, 0);
         check("R7 stalled pwm held high", lows, 0);
      end
      gen_on = 1'b1;
      sync_start();
      measure(-1, 0, hi, len);
      check("R3 width after stall", hi, 30);

      check("R8 rises only at period start", rise_bad, 0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule